// File: doc/BRIEF.md
# Access Permission Checker and Fault Recorder

This block decides whether one memory access may proceed against the 3-bit permission field of an already translated page entry, and keeps a record of the faults it finds. Each access brings four things: its kind (a load, a store, or an instruction fetch), the privilege of the requester, the permission field and modified flag of the entry, and any error code the page walker has already produced. From these the block returns, in the same cycle, an error code, a read/write/execute protection mask for the translation cache, and a trap request that says whether the fault is on an instruction or on data.

Faults are kept in a status register and an address register. A small state machine follows the status register. It has two states. `ST_CLEAR` means no fault is pending. `ST_HELD` means a fault has been recorded and software has not read it yet. The transitions are `FIRST_FAULT` (`ST_CLEAR` to `ST_HELD`), `OVERFLOW` (a further fault while in `ST_HELD` with no read), `READ_CLEAR` (a read with no fault, `ST_HELD` to `ST_CLEAR`) and `READ_REFAULT` (a read and a fault in the same cycle, which stays in or enters `ST_HELD` with a fresh record). A no-fault mode input, and a traps-enabled input, can each hold back the trap. When a fault is held back this way, the access is given full rights instead.

Top module: `apc_fault_unit`

## Requirements
- R1: The access index is a 3-bit value. Bit 2 is the store flag, bit 1 is the instruction fetch flag, and bit 0 is 1 for a supervisor access and 0 for a user access. It is recorded in status bits 7:5 on every fault.
- R2: The rights of a permission value p are as follows. For p = 0..3: read, plus write if p[0] is 1, plus execute if p[1] is 1. For p = 4: execute only. For p = 5: read for a user and read+write for a supervisor. For p = 6: read+execute for a supervisor. For p = 7: all three for a supervisor. A user access to p = 6 or p = 7 gives code 3 (privilege violation). Otherwise the code is 2 (protection error) if a needed right is missing, and 0 if not. A store needs write, a fetch needs execute, and a plain load needs read.
- R3: The protection mask uses bit 2 for read, bit 1 for write and bit 0 for execute. On an allowed access it equals the rights of R2 for that privilege. The write bit is removed while the entry's modified flag is 0.
- R4: A nonzero walker error overrides the table. It is output unchanged as the 10-bit error code and counts as a fault.
- R5: On a fault, the next status value is formed from a base value. The base is 1 if the status was nonzero and no read occurs this cycle, and 0 otherwise. The next status is that base OR (access index << 5) OR the error code OR 2, where bit 1 marks the fault address as valid.
- R6: On every fault, the fault address register loads the access's virtual address. Otherwise it holds its value.
- R7: If no-fault mode is 1 or traps are disabled, a fault raises no trap, and the protection mask is 7 (read, write and execute).
- R8: Otherwise a fault raises a trap request. The trap is marked as an instruction fault exactly when the access was a fetch.
- R9: The status output is the read data in the cycle the read strobe is high. The status is 0 after that edge, unless a fault in the same cycle records onto a zero base.
- R10: Reset clears both registers. While no access is valid, the error code, protection mask and trap outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | Access is a store |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_user | input | 1 | Access is from user mode |
| perm_field | input | 3 | Permission field of the translated entry |
| entry_modified | input | 1 | Modified flag of the translated entry |
| walk_err | input | 10 | Walker error code, 0 if the walk succeeded |
| fault_vaddr | input | VA_W | Virtual address of the access |
| nofault_mode | input | 1 | No-fault mode: faults do not trap |
| traps_en | input | 1 | Traps are enabled |
| status_rd | input | 1 | Software read strobe for the status register |
| err_code | output | 10 | Error code of the access |
| prot_mask | output | 3 | Granted rights {read, write, execute} |
| trap_req | output | 1 | Fault trap requested |
| trap_is_fetch | output | 1 | The trap is an instruction fault |
| fsr_data | output | 10 | Fault status register |
| far_data | output | VA_W | Fault address register |

## Verification
The assertions assume that all inputs are settled before each rising edge. They also assume that the walker error is either 0 or a code with bit 1 clear, so that the valid-address bit and the overflow bit mean only what R5 gives them. The bench drives every input at the falling edge. It uses only walker codes built from a level in bits 9:8 and a type in bits 4:2. It sweeps every combination of store, fetch, privilege, permission and modified flag under each of the four settings of no-fault mode and trap enable, and places read strobes among the faults so that each state machine transition occurs many times.

// File: rtl/apc_pkg.sv
package apc_pkg;

    localparam int ERR_W      = 10;
    localparam int IDX_W      = 3;
    localparam int PERM_W     = 3;
    localparam int IDX_SHIFT  = 5;

    typedef logic [2:0] rights_t;

    localparam rights_t RIGHT_R   = 3'b100;
    localparam rights_t RIGHT_W   = 3'b010;
    localparam rights_t RIGHT_X   = 3'b001;
    localparam rights_t RIGHT_ALL = 3'b111;

    localparam logic [1:0] CODE_OK   = 2'd0;
    localparam logic [1:0] CODE_PROT = 2'd2;
    localparam logic [1:0] CODE_PRIV = 2'd3;

    localparam logic [ERR_W-1:0] FSR_FAV  = ERR_W'(2);
    localparam logic [ERR_W-1:0] FSR_OVFL = ERR_W'(1);

    typedef enum logic [0:0] {
        ST_CLEAR = 1'b0,
        ST_HELD  = 1'b1
    } rec_state_t;

    typedef enum logic [2:0] {
        TR_NONE,
        TR_FIRST_FAULT,
        TR_OVERFLOW,
        TR_READ_CLEAR,
        TR_READ_REFAULT
    } rec_trans_t;

    // Rights granted by a permission value for a given privilege.
    function automatic rights_t mode_rights(input logic user,
                                            input logic [PERM_W-1:0] perm);
        rights_t r;
        unique case (perm)
            3'd0:    r = RIGHT_R;
            3'd1:    r = RIGHT_R | RIGHT_W;
            3'd2:    r = RIGHT_R | RIGHT_X;
            3'd3:    r = RIGHT_ALL;
            3'd4:    r = RIGHT_X;
            3'd5:    r = user ? RIGHT_R : (RIGHT_R | RIGHT_W);
            3'd6:    r = user ? 3'b000 : (RIGHT_R | RIGHT_X);
            3'd7:    r = user ? 3'b000 : RIGHT_ALL;
            default: r = 3'b000;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/apc_perm_check.sv
module apc_perm_check
    import apc_pkg::*;
(
    input  logic              acc_write,
    input  logic              acc_fetch,
    input  logic              acc_user,
    input  logic [PERM_W-1:0] perm_field,
    output logic [IDX_W-1:0]  acc_idx,
    output logic [1:0]        tbl_code,
    output rights_t           rights
);

    rights_t need;
    logic    priv_block;
    logic    missing;

    // R1: index composition
    assign acc_idx = {acc_write, acc_fetch, ~acc_user};

    assign rights = mode_rights(acc_user, perm_field);

    always_comb begin
        need = 3'b000;
        if (acc_write)
            need = need | RIGHT_W;
        if (acc_fetch)
            need = need | RIGHT_X;
        if (!acc_write && !acc_fetch)
            need = RIGHT_R;
    end

    // R2: user access to the two supervisor-only values is a privilege fault
    assign priv_block = acc_user && perm_field[2] && perm_field[1];
    assign missing    = (need & ~rights) != 3'b000;

    always_comb begin
        if (priv_block)
            tbl_code = CODE_PRIV;
        else if (missing)
            tbl_code = CODE_PROT;
        else
            tbl_code = CODE_OK;
    end

endmodule

// File: rtl/apc_prot_gen.sv
module apc_prot_gen
    import apc_pkg::*;
(
    input  logic    acc_valid,
    input  logic    fault,
    input  logic    suppress,
    input  logic    entry_modified,
    input  rights_t rights,
    output rights_t prot_mask
);

    always_comb begin
        if (!acc_valid)
            prot_mask = 3'b000;
        else if (fault && suppress)
            prot_mask = RIGHT_ALL;                // R7
        else if (fault)
            prot_mask = 3'b000;
        else if (!entry_modified)
            prot_mask = rights & ~RIGHT_W;        // R3
        else
            prot_mask = rights;
    end

endmodule

// File: rtl/apc_fault_rec.sv
module apc_fault_rec
    import apc_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec_en,
    input  logic             status_rd,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic [ERR_W-1:0] err_code,
    input  logic [VA_W-1:0]  fault_vaddr,
    output logic [ERR_W-1:0] fsr_data,
    output logic [VA_W-1:0]  far_data
);

    rec_state_t       state_q, state_d;
    rec_trans_t       trans;
    logic [ERR_W-1:0] fsr_q, fsr_d;
    logic [VA_W-1:0]  far_q;
    logic [ERR_W-1:0] rec_word;

    assign rec_word = (ERR_W'(acc_idx) << IDX_SHIFT) | err_code | FSR_FAV;

    // transition selection
    always_comb begin
        trans   = TR_NONE;
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: begin
                if (rec_en) begin
                    trans   = TR_FIRST_FAULT;
                    state_d = ST_HELD;
                end
            end
            ST_HELD: begin
                if (rec_en && status_rd) begin
                    trans   = TR_READ_REFAULT;
                    state_d = ST_HELD;
                end else if (rec_en) begin
                    trans   = TR_OVERFLOW;
                    state_d = ST_HELD;
                end else if (status_rd) begin
                    trans   = TR_READ_CLEAR;
                    state_d = ST_CLEAR;
                end
            end
            default: begin
                trans   = TR_NONE;
                state_d = ST_CLEAR;
            end
        endcase
    end

    // status data per transition (R5, R9)
    always_comb begin
        unique case (trans)
            TR_FIRST_FAULT:  fsr_d = rec_word;
            TR_READ_REFAULT: fsr_d = rec_word;
            TR_OVERFLOW:     fsr_d = FSR_OVFL | rec_word;
            TR_READ_CLEAR:   fsr_d = '0;
            TR_NONE:         fsr_d = fsr_q;
            default:         fsr_d = fsr_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_CLEAR;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsr_q <= '0;
            far_q <= '0;
        end else begin
            fsr_q <= fsr_d;
            if (rec_en)
                far_q <= fault_vaddr;             // R6
        end
    end

    assign fsr_data = fsr_q;
    assign far_data = far_q;

    // R9: state and status register agree
    assert_clear_state_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLEAR) |-> (fsr_q == '0));

    // R5: a recorded fault marks the address valid
    assert_fav_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rec_en |=> fsr_q[1]);

    // R5: a second unread fault sets the overflow bit
    assert_overflow_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_en && !status_rd && fsr_q != '0) |=> fsr_q[0]);

    // R1: access index lands in bits 7:5
    assert_index_field_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rec_en |=> (fsr_q[7:5] == $past(acc_idx)));

    // R6: address captured on fault, held otherwise
    assert_far_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rec_en |=> (far_q == $past(fault_vaddr)));
    assert_far_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_en |=> $stable(far_q));

    // R9: read without fault clears
    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !rec_en) |=> (fsr_q == '0));

endmodule

// File: rtl/apc_fault_unit.sv
module apc_fault_unit
    import apc_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_fetch,
    input  logic              acc_user,
    input  logic [PERM_W-1:0] perm_field,
    input  logic              entry_modified,
    input  logic [ERR_W-1:0]  walk_err,
    input  logic [VA_W-1:0]   fault_vaddr,
    input  logic              nofault_mode,
    input  logic              traps_en,
    input  logic              status_rd,
    output logic [ERR_W-1:0]  err_code,
    output logic [2:0]        prot_mask,
    output logic              trap_req,
    output logic              trap_is_fetch,
    output logic [ERR_W-1:0]  fsr_data,
    output logic [VA_W-1:0]   far_data
);

    logic [IDX_W-1:0] acc_idx;
    logic [1:0]       tbl_code;
    rights_t          rights;
    rights_t          prot_w;
    logic             walk_fail;
    logic             fault;
    logic             suppress;

    apc_perm_check u_check (
        .acc_write  (acc_write),
        .acc_fetch  (acc_fetch),
        .acc_user   (acc_user),
        .perm_field (perm_field),
        .acc_idx    (acc_idx),
        .tbl_code   (tbl_code),
        .rights     (rights)
    );

    // R4: walker error takes precedence over the table
    assign walk_fail = walk_err != '0;

    always_comb begin
        if (!acc_valid)
            err_code = '0;
        else if (walk_fail)
            err_code = walk_err;
        else
            err_code = ERR_W'(tbl_code);
    end

    assign fault    = acc_valid && (walk_fail || tbl_code != CODE_OK);
    assign suppress = nofault_mode || !traps_en;

    apc_prot_gen u_prot (
        .acc_valid      (acc_valid),
        .fault          (fault),
        .suppress       (suppress),
        .entry_modified (entry_modified),
        .rights         (rights),
        .prot_mask      (prot_w)
    );
    assign prot_mask = prot_w;

    // R8
    assign trap_req      = fault && !suppress;
    assign trap_is_fetch = trap_req && acc_fetch;

    apc_fault_rec #(.VA_W(VA_W)) u_rec (
        .clk         (clk),
        .rst_n       (rst_n),
        .rec_en      (fault),
        .status_rd   (status_rd),
        .acc_idx     (acc_idx),
        .err_code    (err_code),
        .fault_vaddr (fault_vaddr),
        .fsr_data    (fsr_data),
        .far_data    (far_data)
    );

    // R8: a trap always carries a nonzero error code
    assert_trap_has_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (err_code != '0));

    // R7: suppression never traps and grants everything on a fault
    assert_suppress_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && err_code != '0 && (nofault_mode || !traps_en))
            |-> (!trap_req && prot_mask == 3'b111));

    // R3: no write right while the entry is unmodified and allowed
    assert_no_write_unmod_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && err_code == '0 && !entry_modified) |-> !prot_mask[1]);

    // R2: user access to supervisor-only values is a privilege fault
    assert_user_priv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && walk_err == '0 && acc_user && perm_field >= 3'd6)
            |-> (err_code == ERR_W'(3)));

    // R10: idle outputs are zero
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (err_code == '0 && prot_mask == 3'b000 && !trap_req));

endmodule

// File: tb/apc_fault_unit_tb_top.sv
module apc_fault_unit_tb_top;

    localparam int VA_W = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            acc_valid = 1'b0, acc_write = 1'b0, acc_fetch = 1'b0, acc_user = 1'b0;
    logic [2:0]      perm_field = '0;
    logic            entry_modified = 1'b0;
    logic [9:0]      walk_err = '0;
    logic [VA_W-1:0] fault_vaddr = '0;
    logic            nofault_mode = 1'b0, traps_en = 1'b1, status_rd = 1'b0;
    logic [9:0]      err_code;
    logic [2:0]      prot_mask;
    logic            trap_req, trap_is_fetch;
    logic [9:0]      fsr_data;
    logic [VA_W-1:0] far_data;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;

    logic [9:0]      m_fsr = '0;
    logic [VA_W-1:0] m_far = '0;

    always #2 clk = ~clk;

    apc_fault_unit #(.VA_W(VA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_fetch(acc_fetch), .acc_user(acc_user), .perm_field(perm_field),
        .entry_modified(entry_modified), .walk_err(walk_err), .fault_vaddr(fault_vaddr),
        .nofault_mode(nofault_mode), .traps_en(traps_en), .status_rd(status_rd),
        .err_code(err_code), .prot_mask(prot_mask), .trap_req(trap_req),
        .trap_is_fetch(trap_is_fetch), .fsr_data(fsr_data), .far_data(far_data)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // rights {R,W,X} computed from the permission bits
    function automatic logic [2:0] exp_rights(input logic user, input logic [2:0] p);
        if (p < 3'd4) return {1'b1, p[0], p[1]};
        if (p == 3'd4) return 3'b001;
        if (user) return (p == 3'd5) ? 3'b100 : 3'b000;
        return (p == 3'd5) ? 3'b110 : (p == 3'd6 ? 3'b101 : 3'b111);
    endfunction

    task automatic do_access(input logic w, input logic f, input logic u, input logic [2:0] p,
                             input logic mod, input logic [9:0] we, input logic [VA_W-1:0] va,
                             input logic nf, input logic te, input logic rd);
        logic [2:0] rt, need, eprot;
        logic [9:0] ecode, base;
        logic [2:0] idx;
        logic       flt, sup;
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_fetch = f; acc_user = u; perm_field = p;
        entry_modified = mod; walk_err = we; fault_vaddr = va; nofault_mode = nf;
        traps_en = te; status_rd = rd;
        #1;
        rt   = exp_rights(u, p);
        need = (w ? 3'b010 : 3'b000) | (f ? 3'b001 : 3'b000) | ((!w && !f) ? 3'b100 : 3'b000);
        idx  = {w, f, !u};
        if (we != 0) ecode = we;                                   // R4
        else if (u && p >= 3'd6) ecode = 10'd3;                    // R2
        else if ((need & ~rt) != 0) ecode = 10'd2;
        else ecode = 10'd0;
        flt = ecode != 0;
        sup = nf || !te;
        if (!flt) eprot = mod ? rt : (rt & 3'b101);                // R3
        else if (sup) eprot = 3'b111;                              // R7
        else eprot = 3'b000;
        chk(err_code == ecode, "R2/R4 err_code", 32'(err_code), 32'(ecode));
        chk(prot_mask == eprot, "R3/R7 prot_mask", 32'(prot_mask), 32'(eprot));
        chk(trap_req == (flt && !sup), "R7/R8 trap_req", 32'(trap_req), 32'(flt && !sup));
        chk(trap_is_fetch == (flt && !sup && f), "R8 trap_is_fetch",
            32'(trap_is_fetch), 32'(flt && !sup && f));
        if (rd) chk(fsr_data == m_fsr, "R9 read data", 32'(fsr_data), 32'(m_fsr));
        base = rd ? 10'd0 : m_fsr;
        if (flt) begin
            if (base != 0) base = 10'd1;
            m_fsr = base | (10'(idx) << 5) | ecode | 10'd2;         // R1 R5
            m_far = va;                                            // R6
        end else begin
            m_fsr = base;
        end
        @(posedge clk); #1;
        chk(fsr_data == m_fsr, "R5/R9 fsr", 32'(fsr_data), 32'(m_fsr));
        chk(far_data == m_far, "R6 far", far_data, m_far);
    endtask

    task automatic idle_cycle(input logic rd);
        @(negedge clk);
        acc_valid = 1'b0; status_rd = rd; walk_err = '0;
        #1;
        chk(err_code == 0 && prot_mask == 0 && !trap_req, "R10 idle outputs",
            {err_code, prot_mask, trap_req}, 32'd0);
        if (rd) chk(fsr_data == m_fsr, "R9 read data idle", 32'(fsr_data), 32'(m_fsr));
        if (rd) m_fsr = '0;
        @(posedge clk); #1;
        chk(fsr_data == m_fsr, "R9 fsr after idle", 32'(fsr_data), 32'(m_fsr));
        chk(far_data == m_far, "R6 far hold", far_data, m_far);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(fsr_data == 0, "R10 reset fsr", 32'(fsr_data), 0);
        chk(far_data == 0, "R10 reset far", far_data, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle_cycle(1'b0);

        // R1 R2 R3 R5 R7 R8 R9: full sweep under each suppression setting
        for (int mode = 0; mode < 4; mode++) begin
            for (int c = 0; c < 128; c++) begin
                do_access(c[6], c[5], c[4], c[3:1], c[0], 10'd0,
                          32'h1000_0000 + 32'(c) * 32'h1357 + 32'(mode) * 32'h0100_0000,
                          mode[0], !mode[1], (c % 3) == 0);
            end
            idle_cycle(1'b1);
            idle_cycle(1'b0);
        end

        // R4: walker errors override an allowed permission
        for (int k = 0; k < 4; k++) begin
            do_access(k[0], k[1], 1'b0, 3'd3, 1'b1, {2'(k), 3'b000, 3'(k + 1), 2'b00},
                      32'hDEAD_0000 + 32'(k), k[1], 1'b1, k == 2);
        end

        // R5 R9: back-to-back faults then reads
        do_access(1'b1, 1'b0, 1'b1, 3'd0, 1'b1, 10'd0, 32'hCAFE_0001, 1'b0, 1'b1, 1'b0);
        do_access(1'b0, 1'b1, 1'b1, 3'd7, 1'b1, 10'd0, 32'hCAFE_0002, 1'b0, 1'b1, 1'b0);
        idle_cycle(1'b1);
        idle_cycle(1'b1);
        do_access(1'b0, 1'b0, 1'b0, 3'd4, 1'b0, 10'd0, 32'hCAFE_0003, 1'b1, 1'b1, 1'b1);
        idle_cycle(1'b0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule